// File: doc/BRIEF.md
# Status Register Write Protection Controller

This block decides whether a request to rewrite the nonvolatile status register of a small serial memory may go ahead. A decoded serial command delivers a one-clock write request together with the proposed register value. The block weighs that request against an external protect line and against an enable field held inside the status register itself. It then either starts an internal programming cycle or refuses the request.

The programming cycle is modelled as a timer. An accepted request raises a busy flag for a fixed, parameterised number of clocks. The new value reaches the register output in the clock where busy falls. The protect line has effect only while the stored enable field is set. Once a cycle has begun, the line cannot stop it. Every refused request gives a single-clock reject pulse.

Top module: `sr_wprot_ctrl`

## Requirements
- R1: When `wp_line` is 0, the stored enable field (`reg_q[7]`) is 1 and busy is low, a request is refused. `reject` is 1 in the following cycle, `busy` stays 0 and `reg_q` is unchanged.
- R2: When `wp_line` is 1 and busy is low, a request is accepted whatever the enable field holds. `busy` is 1 in the following cycle and `reject` stays 0.
- R3: When the enable field is 0, the level of `wp_line` has no effect, so a request with `wp_line` at 0 is accepted as in R2.
- R4: If `wp_line` falls while an accepted cycle runs, the cycle still lasts its full length and commits its value.
- R5: After such a fall, a later request is refused while `wp_line` stays 0 and the committed enable field is 1.
- R6: An accepted request keeps `busy` at 1 for exactly CYCLE_CLKS clocks. `reg_q` keeps its old value for that whole time and shows the requested value from the clock in which `busy` returns to 0.
- R7: A request made while `busy` is 1 is refused with a reject pulse and does not change the running cycle or its value.
- R8: `reject` is a registered pulse, high for exactly one clock per refused request.
- R9: While `rst_n` is low, `reg_q` is 0, `busy` is 0 and `reject` is 0, so protection starts disabled.
- R10: The enable field is bit 7 of the register value. A write can set or clear it, and the new setting applies from the clock in which that write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_line | input | 1 | Protect line; 0 requests protection |
| wr_req | input | 1 | One-clock request to rewrite the register |
| wr_data | input | REG_W | Value proposed by the request |
| reg_q | output | REG_W | Committed register contents |
| busy | output | 1 | Programming cycle in progress |
| reject | output | 1 | One-clock pulse for a refused request |

## Verification
The assertions assume that `wr_req` is sampled as a single-cycle pulse and that `wp_line` and `wr_data` are stable around each rising edge. They also assume that nothing but the block itself changes `reg_q`. The bench drives every input at the falling edge and holds each request for exactly one clock. It changes `wp_line` only between edges, including the mid-cycle drop that R4 needs. It also issues one request while a cycle is running, to exercise R7. A sweep of 64 data and pin combinations follows a reference model of the register in the bench, so the enable field toggles in both directions during the run.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

   // Width of a down-counter that must hold values 0 .. n-1
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   typedef enum logic [1:0] {
      GATE_IDLE   = 2'b00,
      GATE_ACCEPT = 2'b01,
      GATE_REFUSE = 2'b10
   } gate_t;

endpackage

// File: rtl/srwp_gate.sv
module srwp_gate
   import srwp_pkg::*;
(
   input  logic  req,
   input  logic  busy,
   input  logic  prot_en,
   input  logic  wp_line,
   output gate_t verdict
);

   logic blocked;

   // The pin counts only when the stored enable field is set
   assign blocked = busy | (prot_en & ~wp_line);

   always_comb begin
      if (!req)         verdict = GATE_IDLE;
      else if (blocked) verdict = GATE_REFUSE;
      else              verdict = GATE_ACCEPT;
   end

endmodule

// File: rtl/srwp_cycle_timer.sv
module srwp_cycle_timer
   import srwp_pkg::*;
#(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);

   localparam int CW = cnt_width(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("srwp_cycle_timer: CYCLES must be at least 1");
      end

      if (CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy <= 1'b0;
            else if (start) busy <= 1'b1;
            else            busy <= 1'b0;
         end
         assign last = busy;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else if (start) begin
               busy <= 1'b1;
               cnt  <= CW'(CYCLES - 1);
            end else if (busy) begin
               if (cnt == '0) busy <= 1'b0;
               else           cnt  <= cnt - 1'b1;
            end
         end
         assign last = busy && (cnt == '0);

         // A running cycle keeps going until its final clock
         assert_no_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy && !last |=> busy);
      end
   endgenerate

   assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_end_drops_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      last && !start |=> !busy);

endmodule

// File: rtl/srwp_store.sv
module srwp_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         commit,
   output logic [W-1:0] q
);

   logic [W-1:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         q    <= '0;
      end else begin
         if (load)   pend <= d;
         if (commit) q    <= pend;
      end
   end

   assert_commit_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> q == $past(pend));
   assert_hold_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(q));

endmodule

// File: rtl/sr_wprot_ctrl.sv
module sr_wprot_ctrl
   import srwp_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int EN_BIT     = 7,
   parameter int CYCLE_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wp_line,
   input  logic             wr_req,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] reg_q,
   output logic             busy,
   output logic             reject
);

   generate
      if (REG_W < 2) begin : g_bad_w
         $error("sr_wprot_ctrl: REG_W must be at least 2");
      end
      if (EN_BIT >= REG_W || EN_BIT < 0) begin : g_bad_bit
         $error("sr_wprot_ctrl: EN_BIT outside the register");
      end
      if (CYCLE_CLKS < 1) begin : g_bad_cyc
         $error("sr_wprot_ctrl: CYCLE_CLKS must be at least 1");
      end
   endgenerate

   gate_t verdict;
   logic  accept;
   logic  last;
   logic  prot_en;

   assign prot_en = reg_q[EN_BIT];

   srwp_gate u_gate (
      .req     (wr_req),
      .busy    (busy),
      .prot_en (prot_en),
      .wp_line (wp_line),
      .verdict (verdict)
   );

   assign accept = (verdict == GATE_ACCEPT);

   srwp_cycle_timer #(.CYCLES(CYCLE_CLKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy),
      .last  (last)
   );

   srwp_store #(.W(REG_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .d      (wr_data),
      .commit (last),
      .q      (reg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reject <= 1'b0;
      else        reject <= (verdict == GATE_REFUSE);
   end

   assert_protect_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !busy && prot_en && !wp_line |=> reject && !busy && $stable(reg_q));
   assert_pin_high_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !busy && wp_line |=> busy && !reject);
   assert_pin_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !busy && !prot_en |=> busy && !reject);
   assert_busy_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && busy |=> reject);
   assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> !reject);

endmodule

// File: tb/test_sr_wprot_ctrl.sv
module test_sr_wprot_ctrl;

   localparam int N = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wp_line = 1'b1;
   logic       wr_req = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] reg_q;
   logic       busy;
   logic       reject;

   int errors = 0;
   int checks = 0;
   logic [7:0] model = '0;

   always #4 clk = ~clk;

   sr_wprot_ctrl #(.REG_W(8), .EN_BIT(7), .CYCLE_CLKS(N)) i_sr_wprot_ctrl (
      .clk(clk), .rst_n(rst_n), .wp_line(wp_line), .wr_req(wr_req),
      .wr_data(wr_data), .reg_q(reg_q), .busy(busy), .reject(reject)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One request; drop_mid lowers the pin during an accepted cycle (R4)
   task automatic request(input logic [7:0] d, input logic wp, input bit drop_mid);
      bit    acc;
      string rtag;
      acc  = wp || !model[7];
      rtag = !model[7] ? "R3" : (wp ? "R2" : "R1");
      @(negedge clk);
      wr_req = 1'b1; wr_data = d; wp_line = wp;
      @(negedge clk);
      wr_req = 1'b0;
      chk(reject == !acc, rtag, reject, !acc);
      chk(busy == acc, rtag, busy, acc);
      chk(reg_q == model, "R6", reg_q, model);
      if (acc) begin
         for (int c = 1; c < N; c++) begin
            if (c == 1) begin
               if (drop_mid) wp_line = 1'b0;
               wr_req = 1'b1; wr_data = ~d;
            end
            @(negedge clk);
            wr_req = 1'b0;
            chk(busy == 1'b1, drop_mid ? "R4" : "R6", busy, 1);
            chk(reject == (c == 1), "R7", reject, (c == 1));
            chk(reg_q == model, "R6", reg_q, model);
         end
         @(negedge clk);
         model = d;
         chk(busy == 1'b0, "R6", busy, 0);
         chk(reg_q == model, drop_mid ? "R4" : "R6", reg_q, model);
         chk(reject == 1'b0, "R8", reject, 0);
      end else begin
         @(negedge clk);
         chk(reject == 1'b0, "R8", reject, 0);
         chk(busy == 1'b0, "R1", busy, 0);
         chk(reg_q == model, "R1", reg_q, model);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(reg_q == 8'h00, "R9", reg_q, 0);
      chk(busy == 1'b0, "R9", busy, 0);
      chk(reject == 1'b0, "R9", reject, 0);
      rst_n = 1'b1;

      request(8'h80, 1'b0, 0);   // R3 then R10: enable field set with pin low
      request(8'h3C, 1'b0, 0);   // R1: now protected
      request(8'h85, 1'b1, 0);   // R2: pin high overrides
      request(8'h81, 1'b1, 1);   // R4: pin drops mid cycle
      request(8'h00, 1'b0, 0);   // R5: still low, refused
      chk(reg_q == 8'h81, "R5", reg_q, 8'h81);
      request(8'h00, 1'b1, 0);   // R10: field cleared
      request(8'h12, 1'b0, 0);   // R3: pin ignored again

      for (int i = 0; i < 64; i++) begin
         logic [7:0] d;
         logic       wp;
         d  = 8'((i * 37 + 5) & 255);
         wp = i[0] ^ i[3];
         request(d, wp, i[2] & wp);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule